// File: doc/BRIEF.md
# Multi-cycled systolic FIR network

This block is a chain of eight multiply-accumulate stages that forms an FIR filter over 16-bit two's complement samples and yields 32-bit results. A 2-bit speed code sets how many times each stage is reused within one sample period: 1, 2, 4 or 8 clocks. The filter therefore has 8, 16, 32 or 64 taps, and the sample rate is the clock rate divided by the same factor. Partial sums travel from stage to stage once per sample period. A shared history of past samples gives each stage the delayed data it needs.

Coefficients live in an external array. Each stage owns one read lane, so it gets one coefficient per clock: the block drives a tap address per lane and expects the 16-bit coefficient back in the same cycle. Each coefficient is narrowed to 12 bits inside the stage before it is multiplied. A strobe output tells the data source when a new sample is taken. A filter-enable input aligns the first sample with the data stream. An active-low clear empties the network, and a busy flag covers the clearing.

Top module: `fir_systolic_net`

## Requirements
- R1: A coefficient c is narrowed to 12 bits q. If c is not negative, q = c[15:4]. If c is negative, q = c[15:4] plus one when any of c[3:0] is set, so it rounds toward zero.
- R2: Each product is the full 28-bit signed value of sample times q. It is shifted right arithmetically by 4, sign-extended to 32 bits and added modulo 2^32.
- R3: Speed codes 00, 01, 10 and 11 set the reuse factor M to 1, 2, 4 and 8. The result for sample m is the sum over taps k = 0..8M-1 of the R2 term for coefficient address k and sample x[m-k]. Tap 0 meets the newest sample.
- R4: coef_addr holds 8 lanes of 6 bits, with lane s at bits [6s+5:6s]. Lane s carries s*M + p, where p is the cycle within the sample period. The first cycle of each period is p = 0.
- R5: Take the start edge as edge 0. The result for sample m appears after edge (m+8)*M+1 and stays unchanged for the following M cycles.
- R6: stb is high in each cycle whose closing edge samples din, which is once every M cycles. It stays high all the time at speed code 00. It is low while the network is idle.
- R7: The first edge with en high (after en was low) starts filtering and takes din as sample 0, provided the block is not busy. Filtering continues while en stays high. Samples before sample 0 count as zero after reset or clear.
- R8: clr_n sampled low zeroes every accumulator, the sample history and result, and stops filtering. busy is high from that edge until the first edge at which clr_n is sampled high.
- R9: After a clear, an en that is held high has no effect. Only a new low-to-high edge of en restarts filtering.
- R10: The speed code is captured at the start edge. Changes on speed while filtering is running have no effect.
- R11: While rst_n is low (asynchronous), result is 0 and stb and busy are low. Operation resumes two edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| speed | input | 2 | reuse code, captured at start |
| en | input | 1 | filter enable; its rising edge marks sample 0 |
| clr_n | input | 1 | active-low network clear |
| din | input | 16 | input sample, two's complement |
| coef_addr | output | 48 | per-stage coefficient tap addresses |
| coef_data | input | 128 | per-stage 16-bit coefficients, same-cycle reply |
| result | output | 32 | filter output |
| stb | output | 1 | sample strobe, acts as clock enable for the data source |
| busy | output | 1 | clear in progress |

## Verification
The assertions check on every cycle that:
- coefficient narrowing rounds toward zero;
- the phase stays inside the period;
- the strobe stays high at full rate;
- a clear empties each accumulator and raises busy;
- a start resets the phase;
- a shift captures din;
- result moves only on a period boundary.

Only the bench scenarios can show that the chained arithmetic equals the intended tap sum for every speed code, that results arrive with the stated latency, and that the speed latch and the need for a new enable edge behave as required.

// File: rtl/fir_net_pkg.sv
package fir_net_pkg;

  // reuse factor selected by a speed code: 1, 2, 4, 8 ...
  function automatic int unsigned reuse_count(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // largest reuse factor reachable with an SPW-bit speed code
  function automatic int unsigned max_reuse(input int unsigned spw);
    return 32'd1 << ((32'd1 << spw) - 1);
  endfunction

endpackage

// File: rtl/fir_coef_quant.sv
module fir_coef_quant #(
  parameter int CW = 16,
  parameter int QW = 12
) (
  input  logic [CW-1:0]        c_in,
  output logic signed [QW-1:0] q_out
);
  localparam int DROP = CW - QW;

  logic frac_nz;

  always_comb begin
    frac_nz = |c_in[DROP-1:0];
    q_out   = $signed(c_in[CW-1:DROP]) + $signed({{(QW-1){1'b0}}, c_in[CW-1] & frac_nz});
  end

  // R1
  always_comb begin
    if (!$isunknown(c_in)) begin
      quant_toward_zero_chk: assert (c_in[CW-1]
        ? (($signed({q_out, {DROP{1'b0}}}) >= $signed(c_in)) &&
           (($signed({q_out[QW-1], q_out, {DROP{1'b0}}}) - $signed({c_in[CW-1], c_in})) < (1 <<< DROP)))
        : (($signed({q_out, {DROP{1'b0}}}) <= $signed(c_in)) &&
           (($signed({c_in[CW-1], c_in}) - $signed({q_out[QW-1], q_out, {DROP{1'b0}}})) < (1 <<< DROP))));
    end
  end
endmodule

// File: rtl/fir_net_seq.sv
module fir_net_seq #(
  parameter int SPW = 2,
  parameter int PHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SPW-1:0] speed_in,
  input  logic           en,
  input  logic           clr_n,
  output logic [SPW-1:0] spd,
  output logic [PHW-1:0] ph,
  output logic           busy,
  output logic           stb,
  output logic           shift,
  output logic           mac_en,
  output logic           first,
  output logic           clr
);
  logic           run_q, run_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic [SPW-1:0] spd_q, spd_d;
  logic           busy_q, busy_d;
  logic           en_q;
  logic           stb_q, stb_d;
  logic           start;
  logic [PHW-1:0] last_q, last_d;

  always_comb begin
    last_q = PHW'(fir_net_pkg::reuse_count(32'(spd_q)) - 1);
    clr    = ~clr_n;
    start  = en & ~en_q & ~run_q & ~busy_q & ~clr;
    mac_en = run_q & en & ~clr;
    shift  = start | (mac_en & (ph_q == last_q));
    first  = (ph_q == '0);

    run_d  = run_q;
    ph_d   = ph_q;
    spd_d  = spd_q;
    busy_d = 1'b0;
    if (clr) begin
      run_d  = 1'b0;
      ph_d   = '0;
      busy_d = 1'b1;
    end else if (run_q) begin
      if (!en) begin
        run_d = 1'b0;
        ph_d  = '0;
      end else begin
        ph_d = (ph_q == last_q) ? '0 : ph_q + 1'b1;
      end
    end else if (start) begin
      run_d = 1'b1;
      ph_d  = '0;
      spd_d = speed_in;
    end
    last_d = PHW'(fir_net_pkg::reuse_count(32'(spd_d)) - 1);
    stb_d  = run_d & (ph_d == last_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      spd_q  <= '0;
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      spd_q  <= spd_d;
      busy_q <= busy_d;
      en_q   <= en;
      stb_q  <= stb_d;
    end
  end

  assign spd  = spd_q;
  assign ph   = ph_q;
  assign busy = busy_q;
  assign stb  = stb_q;

  // R8
  clr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> busy_q);
  // R9
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !run_q);
  // R6
  stb_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && spd_q == '0) |-> stb_q);
  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= last_q);
  // R7
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && ph_q == '0));
endmodule

// File: rtl/fir_net_delay.sv
module fir_net_delay #(
  parameter int NSTAGE = 8,
  parameter int DW     = 16,
  parameter int HLEN   = 72,
  parameter int SPW    = 2,
  parameter int PHW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 shift,
  input  logic [DW-1:0]        din,
  input  logic [SPW-1:0]       spd,
  input  logic [PHW-1:0]       ph,
  output logic [NSTAGE*DW-1:0] taps
);
  localparam int IW = $clog2(HLEN);

  logic [DW-1:0] hist_q [HLEN];
  logic [DW-1:0] hist_d [HLEN];

  always_comb begin
    hist_d = hist_q;
    if (clr) begin
      for (int i = 0; i < HLEN; i++) hist_d[i] = '0;
    end else if (shift) begin
      hist_d[0] = din;
      for (int i = 1; i < HLEN; i++) hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HLEN; i++) hist_q[i] <= '0;
    end else begin
      for (int i = 0; i < HLEN; i++) hist_q[i] <= hist_d[i];
    end
  end

  // stage s reads the sample delayed by s*(M+1)+p periods
  for (genvar s = 0; s < NSTAGE; s++) begin : g_tap
    logic [IW-1:0] idx;
    always_comb begin
      idx = IW'(s * (fir_net_pkg::reuse_count(32'(spd)) + 1) + 32'(ph));
      taps[s*DW +: DW] = hist_q[idx];
    end
  end

  // R7
  sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (hist_q[0] == $past(din)));
endmodule

// File: rtl/fir_mac_stage.sv
module fir_mac_stage #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int QW = 12,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 first,
  input  logic [DW-1:0]        sample,
  input  logic [CW-1:0]        coef,
  input  logic signed [AW-1:0] chain_in,
  output logic signed [AW-1:0] acc
);
  localparam int PW   = DW + QW;
  localparam int DROP = CW - QW;

  logic signed [QW-1:0] q;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x;
  logic signed [AW-1:0] term;
  logic signed [AW-1:0] acc_q, acc_d;

  fir_coef_quant #(.CW(CW), .QW(QW)) u_quant (
    .c_in  (coef),
    .q_out (q)
  );

  always_comb begin
    prod   = $signed(sample) * q;
    prod_x = AW'(prod);
    term   = prod_x >>> DROP;
    acc_d  = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = (first ? chain_in : acc_q) + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R8
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/fir_systolic_net.sv
module fir_systolic_net #(
  parameter int NSTAGE = 8,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int QW     = 12,
  parameter int AW     = 32,
  parameter int SPW    = 2,
  localparam int MAXR  = int'(fir_net_pkg::max_reuse(SPW)),
  localparam int PHW   = $clog2(MAXR),
  localparam int CAW   = $clog2(NSTAGE * MAXR),
  localparam int HLEN  = NSTAGE * (MAXR + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SPW-1:0]        speed,
  input  logic                  en,
  input  logic                  clr_n,
  input  logic [DW-1:0]         din,
  output logic [NSTAGE*CAW-1:0] coef_addr,
  input  logic [NSTAGE*CW-1:0]  coef_data,
  output logic [AW-1:0]         result,
  output logic                  stb,
  output logic                  busy
);
  logic [1:0]           rsync;
  logic                 rst_i;
  logic [SPW-1:0]       spd;
  logic [PHW-1:0]       ph;
  logic                 shift, mac_en, first, clr;
  logic [NSTAGE*DW-1:0] taps;
  logic signed [AW-1:0] acc [NSTAGE];
  logic signed [AW-1:0] res_q, res_d;

  // reset: asserted asynchronously, released on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  fir_net_seq #(.SPW(SPW), .PHW(PHW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .speed_in (speed),
    .en       (en),
    .clr_n    (clr_n),
    .spd      (spd),
    .ph       (ph),
    .busy     (busy),
    .stb      (stb),
    .shift    (shift),
    .mac_en   (mac_en),
    .first    (first),
    .clr      (clr)
  );

  fir_net_delay #(.NSTAGE(NSTAGE), .DW(DW), .HLEN(HLEN), .SPW(SPW), .PHW(PHW)) u_delay (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (clr),
    .shift (shift),
    .din   (din),
    .spd   (spd),
    .ph    (ph),
    .taps  (taps)
  );

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic signed [AW-1:0] chain;
    if (s == 0) begin : g_head
      assign chain = '0;
    end else begin : g_link
      assign chain = acc[s-1];
    end

    assign coef_addr[s*CAW +: CAW] =
      CAW'(s * fir_net_pkg::reuse_count(32'(spd)) + 32'(ph));

    fir_mac_stage #(.DW(DW), .CW(CW), .QW(QW), .AW(AW)) u_mac (
      .clk      (clk),
      .rst_n    (rst_i),
      .clr      (clr),
      .en       (mac_en),
      .first    (first),
      .sample   (taps[s*DW +: DW]),
      .coef     (coef_data[s*CW +: CW]),
      .chain_in (chain),
      .acc      (acc[s])
    );
  end

  always_comb begin
    res_d = res_q;
    if (clr)                 res_d = '0;
    else if (mac_en & first) res_d = acc[NSTAGE-1];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) res_q <= '0;
    else        res_q <= res_d;
  end

  assign result = res_q;

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!(mac_en && first) && !clr) |=> $stable(res_q));
endmodule

// File: tb/tb_fir_systolic_net.sv
module tb_fir_systolic_net;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   speed;
  logic         en;
  logic         clr_n;
  logic [15:0]  din;
  logic [47:0]  coef_addr;
  logic [127:0] coef_data;
  logic [31:0]  result;
  logic         stb;
  logic         busy;

  logic [15:0]        cmem [64];
  logic signed [15:0] xs   [128];
  int  n_chk  = 0;
  int  n_err  = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  fir_systolic_net dut (
    .clk(clk), .rst_n(rst_n), .speed(speed), .en(en), .clr_n(clr_n), .din(din),
    .coef_addr(coef_addr), .coef_data(coef_data), .result(result), .stb(stb), .busy(busy)
  );

  for (genvar s = 0; s < 8; s++) begin : g_rom
    assign coef_data[s*16 +: 16] = cmem[coef_addr[s*6 +: 6]];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [11:0] q12(input logic [15:0] c);
    return c[15] ? $signed(c[15:4]) + 12'sd1 * (|c[3:0]) : $signed(c[15:4]);
  endfunction

  function automatic logic signed [31:0] model_y(input int m, input int mm);
    logic signed [31:0] sum = 0;
    for (int k = 0; k < 8 * mm; k++) begin
      if (m - k >= 0) begin
        logic signed [27:0] p;
        p   = xs[m-k] * q12(cmem[k]);
        sum = sum + (32'(p) >>> 4);
      end
    end
    return sum;
  endfunction

  task automatic fill(input int kind);
    for (int i = 0; i < 128; i++) begin
      case (kind)
        0: xs[i] = i[0] ? 16'sh7FFF : 16'sh8000;
        1: xs[i] = (i == 0) ? 16'sh4000 : 16'sh0000;
        2: xs[i] = 16'((i * 31337) ^ (i << 7));
        default: xs[i] = 16'(-1000 * i);
      endcase
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; clr_n = 1'b1; speed = 2'b00; din = '0;
    repeat (3) @(negedge clk);
    chk(result === 32'd0, "R11 result", result, 0);
    chk(stb === 1'b0, "R11 stb", stb, 0);
    chk(busy === 1'b0, "R11 busy", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // full filtering run at one speed code; checks R3 R4 R5 R6 R10 and R2 via data
  task automatic t_run(input int code, input int nsamp, input string tag);
    int mm = 1 << code;
    int nxt = 1;
    int kmax = (nsamp + 8) * mm + 1;
    bit have = 0;
    logic signed [31:0] expv = 0;
    do_clear();
    speed = 2'(code); en = 1'b0;
    @(negedge clk); en = 1'b1; din = xs[0];
    for (int k = 0; k <= kmax; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 3) speed = ~2'(code);  // R10: must be ignored
      chk(stb === ((k % mm) == mm - 1), {"R6 stb ", tag}, stb, (k % mm) == mm - 1);
      if (k == 2 * mm - 1) begin
        for (int s = 0; s < 8; s++)
          chk(coef_addr[s*6 +: 6] === 6'(s * mm + (k % mm)), {"R4 lane ", tag},
              coef_addr[s*6 +: 6], s * mm + (k % mm));
      end
      if (k >= 1 && ((k - 1) % mm) == 0 && (k - 1) / mm >= 8) begin
        expv = model_y((k - 1) / mm - 8, mm);
        have = 1;
        chk($signed(result) === expv, {"R2 R3 R5 R10 result ", tag}, $signed(result), expv);
      end else if (have) begin
        chk($signed(result) === expv, {"R5 hold ", tag}, $signed(result), expv);
      end
      if (stb) begin din = xs[nxt]; nxt++; end
    end
    en = 1'b0;
  endtask

  // clear while running; en held high must not restart (R8, R9)
  task automatic t_clear();
    fill(3);
    do_clear();
    speed = 2'b00; en = 1'b0;
    @(negedge clk); en = 1'b1; din = xs[0];
    for (int k = 1; k < 20; k++) begin @(negedge clk); din = xs[k]; end
    chk(stb === 1'b1, "R7 running", stb, 1);
    clr_n = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1, "R8 busy", busy, 1);
    chk(result === 32'd0, "R8 result", result, 0);
    chk(stb === 1'b0, "R8 stb", stb, 0);
    clr_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R8 busy drop", busy, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(stb === 1'b0, "R9 no restart", stb, 0);
      chk(result === 32'd0, "R9 result", result, 0);
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      case (k)
        0: cmem[k] = 16'h8000;
        1: cmem[k] = 16'hFFF1;
        2: cmem[k] = 16'h7FFF;
        3: cmem[k] = 16'hFFF0;
        default: cmem[k] = 16'((k * 40503 + 7) ^ (k << 11));
      endcase
    end
    t_reset();
    fill(0); t_run(0, 24, "x1 extremes");
    fill(1); t_run(1, 24, "x2 impulse");
    fill(2); t_run(2, 24, "x4 mixed");
    fill(3); t_run(3, 16, "x8 ramp");
    t_clear();
    fill(2); t_run(1, 20, "x2 after clear");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule